// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the program counter of a single-cycle 32-bit processor and works out the address of the following instruction on every clock. Each cycle the decoder supplies a two-bit source code. The unit then picks one of four candidates for the next PC: the sequential address, a conditional branch relative to the incremented PC, a jump through a register value, or an absolute jump built from the instruction's 26-bit target field. The incremented PC (PC+4) is also driven out. The register file writes it as the return address when a jump-and-link is taken.

Advance follows one back-pressure rule. The PC register loads a new value only in a cycle where the instruction-ready input is high and the halt input is low. In any other cycle it keeps its value. The candidate addresses are still computed, but they are discarded. There is no other handshake. The source code, branch decision, offset, target field and register value are sampled only in an advancing cycle.

Top module: `npc_unit`

## Requirements
- R1: An active-low reset, asynchronous to the clock, forces the PC to address 0x00000000. The PC stays there while reset is held.
- R2: The incremented-PC output always equals the current PC plus 4, modulo 2^32.
- R3: In an advancing cycle with source code 2'b00, the next PC is PC+4. The branch-taken input has no effect in this case.
- R4: In an advancing cycle with source code 2'b01 and branch-taken high, the next PC is (PC+4) + (offset << 2), modulo 2^32. The offset input carries the 16-bit displacement already sign-extended to 32 bits, so negative offsets move the PC backward.
- R5: In an advancing cycle with source code 2'b01 and branch-taken low, the next PC is PC+4.
- R6: In an advancing cycle with source code 2'b10, the next PC is the register value input, taken unchanged. Branch-taken is ignored.
- R7: In an advancing cycle with source code 2'b11, the next PC is {PC+4 bits 31:28, target field bits 25:0, 2'b00}. Branch-taken is ignored.
- R8: While halt is high, the PC holds its value whatever the source code and ready inputs are.
- R9: While instruction-ready is low, the PC holds its value.
- R10: All address arithmetic wraps at 2^32. When the PC is 0xFFFFFFFC, a sequential step gives 0x00000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_ready | input | 1 | High when the current instruction may retire and the PC may advance |
| halt_req | input | 1 | High stops PC advancement |
| pc_src | input | 2 | Next-PC source: 00 sequential, 01 branch, 10 register, 11 absolute |
| br_taken | input | 1 | Branch condition result, used only with source 01 |
| br_offset | input | 32 | Sign-extended branch displacement in words |
| jmp_field | input | 26 | Absolute jump target field |
| rs_value | input | 32 | Register value for register-indirect jumps |
| pc_q | output | 32 | Current program counter |
| pc_plus4 | output | 32 | Current PC plus 4, the link value |

## Verification
A change on the selection inputs shows up on `pc_q` exactly one rising edge later. `pc_plus4` follows `pc_q` in the same cycle, with no further delay. The driver applies each stimulus on a falling edge and pushes the PC it expects after the next rising edge into a queue. The monitor pops that entry one time step after the rising edge, so every comparison falls on the first cycle in which the new value is due. Reset is checked on its own, while it is still asserted and before any stimulus is queued.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [1:0] {
    PCS_SEQ    = 2'b00,
    PCS_BRANCH = 2'b01,
    PCS_REG    = 2'b10,
    PCS_ABS    = 2'b11
  } pc_src_e;

endpackage

// File: rtl/npc_incr.sv
module npc_incr #(
  parameter int ADDR_W    = 32,
  parameter int STEP_BYTES = 4
) (
  input  logic [ADDR_W-1:0] pc_cur,
  output logic [ADDR_W-1:0] pc_inc
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP_BYTES);

  always_comb begin
    pc_inc = pc_cur + STEP_V;
  end
endmodule

// File: rtl/npc_targets.sv
module npc_targets #(
  parameter int ADDR_W     = 32,
  parameter int JFIELD_W   = 26,
  parameter int WORD_SHIFT = 2
) (
  input  logic [ADDR_W-1:0]   pc_inc,
  input  logic [ADDR_W-1:0]   br_offset,
  input  logic [JFIELD_W-1:0] jmp_field,
  output logic [ADDR_W-1:0]   br_target,
  output logic [ADDR_W-1:0]   abs_target
);
  localparam int UPPER_W = ADDR_W - JFIELD_W - WORD_SHIFT;

  logic [ADDR_W-1:0] disp_bytes;

  always_comb begin
    disp_bytes = br_offset << WORD_SHIFT;
    br_target  = pc_inc + disp_bytes;
  end

  generate
    if (UPPER_W > 0) begin : g_region
      always_comb begin
        abs_target = {pc_inc[ADDR_W-1 -: UPPER_W], jmp_field, {WORD_SHIFT{1'b0}}};
      end
    end else begin : g_flat
      always_comb begin
        abs_target = ADDR_W'({jmp_field, {WORD_SHIFT{1'b0}}});
      end
    end
  endgenerate
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  pc_src_e           src,
  input  logic              taken,
  input  logic [ADDR_W-1:0] seq_addr,
  input  logic [ADDR_W-1:0] br_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [ADDR_W-1:0] abs_addr,
  output logic [ADDR_W-1:0] next_addr
);
  always_comb begin
    unique case (src)
      PCS_SEQ:    next_addr = seq_addr;
      PCS_BRANCH: next_addr = taken ? br_addr : seq_addr;
      PCS_REG:    next_addr = reg_addr;
      PCS_ABS:    next_addr = abs_addr;
      default:    next_addr = seq_addr;
    endcase
  end
endmodule

// File: rtl/npc_pc_reg.sv
module npc_pc_reg #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RESET_PC;
    end else if (adv) begin
      q <= d;
    end
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int JFIELD_W   = 26,
  parameter int WORD_SHIFT = 2,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                instr_ready,
  input  logic                halt_req,
  input  logic [1:0]          pc_src,
  input  logic                br_taken,
  input  logic [ADDR_W-1:0]   br_offset,
  input  logic [JFIELD_W-1:0] jmp_field,
  input  logic [ADDR_W-1:0]   rs_value,
  output logic [ADDR_W-1:0]   pc_q,
  output logic [ADDR_W-1:0]   pc_plus4
);
  localparam int STEP_BYTES = 1 << WORD_SHIFT;

  logic [ADDR_W-1:0] pc_r;
  logic [ADDR_W-1:0] seq_w;
  logic [ADDR_W-1:0] br_w;
  logic [ADDR_W-1:0] abs_w;
  logic [ADDR_W-1:0] nxt_w;
  logic              advance;
  pc_src_e           src_w;

  always_comb begin
    src_w   = pc_src_e'(pc_src);
    advance = instr_ready & ~halt_req;
  end

  npc_incr #(.ADDR_W(ADDR_W), .STEP_BYTES(STEP_BYTES)) u_incr (
    .pc_cur (pc_r),
    .pc_inc (seq_w)
  );

  npc_targets #(.ADDR_W(ADDR_W), .JFIELD_W(JFIELD_W), .WORD_SHIFT(WORD_SHIFT)) u_tgt (
    .pc_inc     (seq_w),
    .br_offset  (br_offset),
    .jmp_field  (jmp_field),
    .br_target  (br_w),
    .abs_target (abs_w)
  );

  npc_select #(.ADDR_W(ADDR_W)) u_sel (
    .src       (src_w),
    .taken     (br_taken),
    .seq_addr  (seq_w),
    .br_addr   (br_w),
    .reg_addr  (rs_value),
    .abs_addr  (abs_w),
    .next_addr (nxt_w)
  );

  npc_pc_reg #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_pc (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (advance),
    .d     (nxt_w),
    .q     (pc_r)
  );

  assign pc_q     = pc_r;
  assign pc_plus4 = seq_w;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int ADDR_W   = 32,
  parameter int JFIELD_W = 26
) (
  input logic                clk,
  input logic                rst_n,
  input logic                instr_ready,
  input logic                halt_req,
  input logic [1:0]          pc_src,
  input logic                br_taken,
  input logic [ADDR_W-1:0]   br_offset,
  input logic [JFIELD_W-1:0] jmp_field,
  input logic [ADDR_W-1:0]   rs_value,
  input logic [ADDR_W-1:0]   pc_q,
  input logic [ADDR_W-1:0]   pc_plus4
);
  logic go;
  assign go = instr_ready && !halt_req;

  assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (go && pc_src == 2'b00) |=> (pc_q == $past(pc_plus4)));

  assert_branch_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (go && pc_src == 2'b01 && br_taken) |=>
      (pc_q == $past(pc_plus4) + ($past(br_offset) << 2)));

  assert_branch_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (go && pc_src == 2'b01 && !br_taken) |=> (pc_q == $past(pc_plus4)));

  assert_reg_jump_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (go && pc_src == 2'b10) |=> (pc_q == $past(rs_value)));

  assert_abs_jump_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (go && pc_src == 2'b11) |=>
      (pc_q[JFIELD_W+1:2] == $past(jmp_field) && pc_q[1:0] == 2'b00));

  assert_halt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |=> $stable(pc_q));

  assert_ready_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_ready |=> $stable(pc_q));
endmodule

bind npc_unit npc_unit_chk #(.ADDR_W(ADDR_W), .JFIELD_W(JFIELD_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_ready (instr_ready),
  .halt_req    (halt_req),
  .pc_src      (pc_src),
  .br_taken    (br_taken),
  .br_offset   (br_offset),
  .jmp_field   (jmp_field),
  .rs_value    (rs_value),
  .pc_q        (pc_q),
  .pc_plus4    (pc_plus4)
);

// File: tb/sim_npc_unit.sv
module sim_npc_unit;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [31:0] exp_pc;
    string       tag;
  } exp_item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_ready = 1'b0;
  logic        halt_req = 1'b0;
  logic [1:0]  pc_src = 2'b00;
  logic        br_taken = 1'b0;
  logic [31:0] br_offset = '0;
  logic [25:0] jmp_field = '0;
  logic [31:0] rs_value = '0;
  logic [31:0] pc_q;
  logic [31:0] pc_plus4;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] model_pc = '0;
  exp_item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  npc_unit u0 (
    .clk(clk), .rst_n(rst_n), .instr_ready(instr_ready), .halt_req(halt_req),
    .pc_src(pc_src), .br_taken(br_taken), .br_offset(br_offset),
    .jmp_field(jmp_field), .rs_value(rs_value), .pc_q(pc_q), .pc_plus4(pc_plus4)
  );

  task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic rdy, logic hlt, logic [1:0] src, logic tk,
                      logic [31:0] off, logic [25:0] fld, logic [31:0] rsv);
    logic [31:0] seq;
    logic [31:0] nxt;
    exp_item_t it;
    @(negedge clk);
    instr_ready = rdy; halt_req = hlt; pc_src = src; br_taken = tk;
    br_offset = off; jmp_field = fld; rs_value = rsv;
    seq = model_pc + 32'd4;
    case (src)
      2'b00: nxt = seq;
      2'b01: nxt = tk ? seq + (off << 2) : seq;
      2'b10: nxt = rsv;
      default: nxt = {seq[31:28], fld, 2'b00};
    endcase
    if (rdy && !hlt) model_pc = nxt;
    it.exp_pc = model_pc;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: compare one step after each rising edge
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_item_t it;
      it = sb_q.pop_front();
      check32(it.tag, pc_q, it.exp_pc);
      check32({it.tag, " R2 link"}, pc_plus4, it.exp_pc + 32'd4);
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check32("R1 reset pc", pc_q, 32'h0);
    check32("R2 reset link", pc_plus4, 32'h4);
    @(negedge clk);
    rst_n = 1'b1;

    step("R3 seq a", 1, 0, 2'b00, 0, 0, 0, 0);
    step("R3 seq b", 1, 0, 2'b00, 0, 0, 0, 0);
    step("R3 seq taken ignored", 1, 0, 2'b00, 1, 32'h100, 0, 0);
    step("R4 branch fwd", 1, 0, 2'b01, 1, 32'h10, 0, 0);
    step("R4 branch back", 1, 0, 2'b01, 1, 32'hFFFF_FFFA, 0, 0);
    step("R5 branch not taken", 1, 0, 2'b01, 0, 32'h40, 0, 0);
    step("R6 reg jump", 1, 0, 2'b10, 1, 32'h55, 0, 32'h0040_1230);
    step("R7 abs jump", 1, 0, 2'b11, 1, 0, 26'h2AB_CDEF, 0);
    step("R6 reg jump high", 1, 0, 2'b10, 0, 0, 0, 32'hF000_0010);
    step("R7 abs keeps region", 1, 0, 2'b11, 0, 0, 26'h000_0100, 0);
    step("R8 halt hold", 1, 1, 2'b10, 0, 0, 0, 32'h1234_5678);
    step("R8 halt hold abs", 1, 1, 2'b11, 0, 0, 26'h3FF_FFFF, 0);
    step("R9 not ready hold", 0, 0, 2'b01, 1, 32'h8, 0, 0);
    step("R9 both hold", 0, 1, 2'b00, 0, 0, 0, 0);
    step("R6 jump to top", 1, 0, 2'b10, 0, 0, 0, 32'hFFFF_FFFC);
    step("R10 seq wrap", 1, 0, 2'b00, 0, 0, 0, 0);
    step("R6 jump near top", 1, 0, 2'b10, 0, 0, 0, 32'hFFFF_FFF0);
    step("R10 branch wrap", 1, 0, 2'b01, 1, 32'h4, 0, 0);
    step("R4 branch zero", 1, 0, 2'b01, 1, 32'h0, 0, 0);

    // mid-run reset
    @(negedge clk);
    instr_ready = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check32("R1 async reset", pc_q, 32'h0);
    model_pc = '0;
    @(negedge clk);
    rst_n = 1'b1;
    step("R3 seq after reset", 1, 0, 2'b00, 0, 0, 0, 0);
    step("R3 seq after reset b", 1, 0, 2'b00, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule